// File: doc/BRIEF.md
# Voltage-Frequency Operating-Point Sequencer

This block moves a processor core from one operating point to another when a load monitor asks for it. Each operating point is a small index; the block turns that index into a supply-level code for an external regulator and a clock code for an external clock generator. It orders the two changes by direction. When performance rises, the supply climbs first and the clock follows. When performance falls, the clock drops first and the supply follows. The supply code never jumps: it walks one level at a time, and after every level it waits a fixed, parameterised settling interval before it moves again.

Requests arrive on a valid/ready channel carrying a target index. A request is taken when `req_valid` and `req_ready` are both high at a rising clock edge. One request can wait in a holding slot while a transition runs. `req_ready` is low whenever that slot is occupied, so a second queued request is held off by back-pressure. The source must keep `req_valid` and `req_idx` steady until the request is taken. A running transition is never cut short; the held request starts only after it finishes. `busy` is high while any accepted request is unfinished. `done` pulses once as each transition ends.

Top module: `dvfs_seq`

## Requirements
- R1: After reset the supply code and the clock code are both 0 (operating point 0), `busy` and `done` are low, and `req_ready` is high.
- R2: When a transition to index i ends, the supply code equals floor(i*(VLEVELS-1)/(NUM_PTS-1)) and the clock code equals floor(i*(FSTEPS-1)/(NUM_PTS-1)). Supply code 0 means the lowest rail (1.1 V) and code VLEVELS-1 the highest (1.6 V). Clock code k means 200 MHz plus k steps of 33 MHz. The mapping never gives a higher index a lower code.
- R3: The supply code changes by exactly one level at a time. Consecutive level changes within a transition are SETTLE_CYC+1 cycles apart. A transition that is started directly from idle and spans N levels raises `done` N*(SETTLE_CYC+1)+3 clock edges after the edge that accepted it.
- R4: On a rise, the clock code stays unchanged until the supply code has reached its target. At no time does the clock code exceed the highest clock code that any operating point at or below the present supply code uses.
- R5: On a fall, the clock code is set to its target before the supply code takes its first step down.
- R6: `done` is high for exactly one cycle per transition. In that cycle both codes hold their final values, and `busy` is low unless another request is already waiting.
- R7: A request taken while a transition runs waits in the slot. `req_ready` stays low while the slot is full. The running transition completes to its own target before the waiting one begins.
- R8: A request for the operating point already in force leaves both codes unchanged and still produces a `done` pulse.
- R9: `busy` is high from the cycle after a request is taken until the cycle in which its `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request channel valid |
| req_ready | output | 1 | Request channel ready: the holding slot is empty |
| req_idx | input | $clog2(NUM_PTS) | Target operating-point index |
| volt_code | output | $clog2(VLEVELS) | Supply level code to the regulator |
| freq_code | output | $clog2(FSTEPS) | Clock step code to the clock generator |
| busy | output | 1 | A transition is running or waiting |
| done | output | 1 | One-cycle pulse when a transition ends |

## Verification
Counted from the edge that accepts a request with the block idle, a rise moves the supply at edge 2 and a fall moves the clock at edge 2 and the supply at edge 3. Each further level follows SETTLE_CYC+1 edges later, and `done` arrives at edge N*(SETTLE_CYC+1)+3. The bench drives and samples on the falling edge. It counts falling edges from the request and compares that count with the formula, which it computes from its own copy of the index mapping. A falling-edge monitor checks every supply change for size and spacing, and every clock change for order against the running target. Queued requests are checked against the order in which they complete, not by cycle count.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FFIRST,
    ST_VSTEP,
    ST_VWAIT,
    ST_FSET
  } seq_state_e;

  function automatic int unsigned opp_volt(int unsigned idx, int unsigned npts,
                                           int unsigned vlev);
    if (npts < 2) return 0;
    return (idx * (vlev - 1)) / (npts - 1);
  endfunction

  function automatic int unsigned opp_freq(int unsigned idx, int unsigned npts,
                                           int unsigned fsteps);
    if (npts < 2) return 0;
    return (idx * (fsteps - 1)) / (npts - 1);
  endfunction

  // highest clock code used by any operating point whose supply code is <= v
  function automatic int unsigned freq_cap(int unsigned v, int unsigned npts,
                                           int unsigned vlev, int unsigned fsteps);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < npts; i++) begin
      if (opp_volt(i, npts, vlev) <= v) r = opp_freq(i, npts, fsteps);
    end
    return r;
  endfunction

endpackage

// File: rtl/dvfs_opp_map.sv
module dvfs_opp_map #(
  parameter int NUM_PTS = 16,
  parameter int VLEVELS = 32,
  parameter int FSTEPS  = 16,
  localparam int IDX_W  = $clog2(NUM_PTS),
  localparam int V_W    = $clog2(VLEVELS),
  localparam int F_W    = $clog2(FSTEPS)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [V_W-1:0]   vcode,
  output logic [F_W-1:0]   fcode
);
  import dvfs_pkg::*;

  logic [V_W-1:0] vtab [NUM_PTS];
  logic [F_W-1:0] ftab [NUM_PTS];

  for (genvar g = 0; g < NUM_PTS; g++) begin : g_pt
    assign vtab[g] = V_W'(opp_volt(g, NUM_PTS, VLEVELS));
    assign ftab[g] = F_W'(opp_freq(g, NUM_PTS, FSTEPS));
  end

  assign vcode = vtab[idx];
  assign fcode = ftab[idx];

endmodule

// File: rtl/dvfs_req_slot.sv
module dvfs_req_slot #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  input  logic             out_take
);
  logic             full_q;
  logic [IDX_W-1:0] idx_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      idx_q  <= in_idx;
    end else if (out_take) begin
      full_q <= 1'b0;
    end
  end

  // R7: a waiting request is neither lost nor altered until it is taken
  a_r7_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_take) |=> (out_valid && $stable(out_idx)));

  // R7: the slot never accepts while it is occupied
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_take) |=> $stable(idx_q));

endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
  parameter int SETTLE_CYC = 1000000,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3: a fresh load always starts a full settling window
  a_r3_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (load && SETTLE_CYC > 1) |=> !expired);

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int NUM_PTS    = 16,
  parameter int VLEVELS    = 32,
  parameter int FSTEPS     = 16,
  parameter int SETTLE_CYC = 1000000,
  localparam int IDX_W = $clog2(NUM_PTS),
  localparam int V_W   = $clog2(VLEVELS),
  localparam int F_W   = $clog2(FSTEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  output logic [V_W-1:0]   volt_code,
  output logic [F_W-1:0]   freq_code,
  output logic             busy,
  output logic             done
);
  import dvfs_pkg::*;

  localparam logic [V_W-1:0] V_ONE = V_W'(1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] cur_idx_q;
  logic [V_W-1:0]   volt_q, tgt_v_q;
  logic [F_W-1:0]   freq_q, tgt_f_q;
  logic             up_q;
  logic             done_q;

  logic             slot_valid;
  logic [IDX_W-1:0] slot_idx;
  logic             slot_take;
  logic [V_W-1:0]   map_v;
  logic [F_W-1:0]   map_f;
  logic             tmr_load;
  logic             tmr_expired;

  dvfs_req_slot #(.IDX_W(IDX_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_idx    (req_idx),
    .out_valid (slot_valid),
    .out_idx   (slot_idx),
    .out_take  (slot_take)
  );

  dvfs_opp_map #(.NUM_PTS(NUM_PTS), .VLEVELS(VLEVELS), .FSTEPS(FSTEPS)) u_map (
    .idx   (slot_idx),
    .vcode (map_v),
    .fcode (map_f)
  );

  dvfs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .expired (tmr_expired)
  );

  assign slot_take = (state_q == ST_IDLE) && slot_valid;
  assign tmr_load  = (state_q == ST_VSTEP) && (volt_q != tgt_v_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_idx_q <= '0;
      volt_q    <= '0;
      freq_q    <= '0;
      tgt_v_q   <= '0;
      tgt_f_q   <= '0;
      up_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (slot_valid) begin
            tgt_v_q   <= map_v;
            tgt_f_q   <= map_f;
            up_q      <= (slot_idx > cur_idx_q);
            cur_idx_q <= slot_idx;
            state_q   <= (slot_idx > cur_idx_q) ? ST_VSTEP : ST_FFIRST;
          end
        end
        ST_FFIRST: begin
          freq_q  <= tgt_f_q;
          state_q <= ST_VSTEP;
        end
        ST_VSTEP: begin
          if (volt_q < tgt_v_q) begin
            volt_q  <= volt_q + V_ONE;
            state_q <= ST_VWAIT;
          end else if (volt_q > tgt_v_q) begin
            volt_q  <= volt_q - V_ONE;
            state_q <= ST_VWAIT;
          end else if (up_q) begin
            state_q <= ST_FSET;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_VWAIT: begin
          if (tmr_expired) state_q <= ST_VSTEP;
        end
        ST_FSET: begin
          freq_q  <= tgt_f_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign volt_code = volt_q;
  assign freq_code = freq_q;
  assign done      = done_q;
  assign busy      = (state_q != ST_IDLE) || slot_valid;

  // R3: the supply code only ever moves by one level
  a_r3_single_level: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_q != $past(volt_q)) |->
      ((volt_q == $past(volt_q) + V_ONE) || (volt_q == $past(volt_q) - V_ONE)));

  // R4: the clock never runs ahead of what the present supply supports
  a_r4_clock_under_supply: assert property (@(posedge clk) disable iff (!rst_n)
    freq_q <= F_W'(freq_cap(volt_q, NUM_PTS, VLEVELS, FSTEPS)));

  // R4: while the supply climbs the clock is frozen
  a_r4_freq_frozen_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VWAIT && up_q) |-> $stable(freq_q));

  // R5: on a fall the clock is already at target while the supply settles
  a_r5_freq_first_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VWAIT && !up_q) |-> (freq_q == tgt_f_q));

  // R6: done is a single-cycle pulse carrying the final codes
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r6_done_final: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (volt_q == tgt_v_q && freq_q == tgt_f_q));

  // R7: no new target is loaded while a transition runs
  a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(tgt_v_q));

endmodule

// File: tb/dvfs_seq_tb.sv
module dvfs_seq_tb;
  localparam int NP = 16, VL = 32, FS = 16, SC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_idx = '0;
  logic       req_ready, busy, done;
  logic [4:0] volt_code;
  logic [3:0] freq_code;

  always #10 clk = ~clk;

  dvfs_seq #(.NUM_PTS(NP), .VLEVELS(VL), .FSTEPS(FS), .SETTLE_CYC(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .volt_code(volt_code), .freq_code(freq_code),
    .busy(busy), .done(done));

  int checks = 0, errors = 0;
  int e3 = 0, e4 = 0, e5 = 0;
  int last_pt = 0;

  function automatic int bv(int i); return i * (VL - 1) / (NP - 1); endfunction
  function automatic int bf(int i); return i * (FS - 1) / (NP - 1); endfunction
  function automatic int bcap(int v);
    int r = 0;
    for (int i = 0; i < NP; i++) if (bv(i) <= v) r = bf(i);
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target queue mirrored by the monitor
  int tq[8];
  int qh = 0, qt = 0;
  bit active = 0, act_up = 0;
  int act_tgt = 0, mon_pt = 0;
  int cyc = 0, last_step = -1;
  logic [4:0] pv = '0;
  logic [3:0] pf = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!active && qh != qt) begin
        active = 1; act_tgt = tq[qh % 8]; act_up = act_tgt > mon_pt; last_step = -1;
      end
      if (volt_code != pv) begin
        if (!(int'(volt_code) == int'(pv) + 1 || int'(volt_code) == int'(pv) - 1)) e3++;
        if (last_step >= 0 && cyc - last_step != SC + 1) e3++;
        last_step = cyc;
        if (active && !act_up && int'(freq_code) != bf(act_tgt)) e5++;
      end
      if (freq_code != pf && active && act_up && int'(volt_code) != bv(act_tgt)) e4++;
      if (int'(freq_code) > bcap(volt_code)) e4++;
      if (done && active) begin
        mon_pt = act_tgt; qh++; active = 0;
      end
      pv = volt_code; pf = freq_code;
    end
  end

  task automatic send(int idx);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_idx = 4'(idx);
    tq[qt % 8] = idx; qt++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // single request from idle, full timing and result checks
  task automatic run_one(int idx);
    int n, c, from;
    from = last_pt;
    n = (bv(idx) > bv(from)) ? bv(idx) - bv(from) : bv(from) - bv(idx);
    send(idx);
    c = 1;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    while (!done && c < 2000) begin @(negedge clk); c++; end
    chk(c == n * (SC + 1) + 4, "R3 done latency", c, n * (SC + 1) + 4);
    chk(int'(volt_code) == bv(idx), "R2 volt code", volt_code, bv(idx));
    chk(int'(freq_code) == bf(idx), "R2 freq code", freq_code, bf(idx));
    chk(busy == 1'b0, "R6 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    last_pt = idx;
  endtask

  task automatic wait_done();
    int c = 0;
    while (!done && c < 2000) begin @(negedge clk); c++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(volt_code == 0, "R1 volt reset", volt_code, 0);
    chk(freq_code == 0, "R1 freq reset", freq_code, 0);
    chk(busy == 0, "R1 busy reset", busy, 0);
    chk(done == 0, "R1 done reset", done, 0);
    chk(req_ready == 1, "R1 ready reset", req_ready, 1);

    // full-range rise and fall (R4, R5)
    run_one(NP - 1);
    run_one(0);
    run_one(5);
    // R8 same point
    run_one(5);
    chk(int'(volt_code) == bv(5), "R8 volt unchanged", volt_code, bv(5));

    // R7 queued request
    send(NP - 1);
    chk(req_ready == 1'b0, "R7 ready low while slot full", req_ready, 0);
    send(3);
    chk(req_ready == 1'b0, "R7 ready low with waiting request", req_ready, 0);
    chk(busy == 1'b1, "R9 busy with waiting request", busy, 1);
    wait_done();
    chk(int'(volt_code) == bv(NP - 1), "R7 first completes volt", volt_code, bv(NP - 1));
    chk(int'(freq_code) == bf(NP - 1), "R7 first completes freq", freq_code, bf(NP - 1));
    chk(busy == 1'b1, "R6 busy stays with waiting request", busy, 1);
    @(negedge clk);
    wait_done();
    chk(int'(volt_code) == bv(3), "R7 second volt", volt_code, bv(3));
    chk(int'(freq_code) == bf(3), "R7 second freq", freq_code, bf(3));
    @(negedge clk);
    last_pt = 3;

    // constrained random targets
    for (int k = 0; k < 25; k++) begin
      run_one(int'($urandom_range(NP - 1, 0)));
    end

    repeat (3) @(negedge clk);
    chk(e3 == 0, "R3 step size and spacing", e3, 0);
    chk(e4 == 0, "R4 clock order on rise", e4, 0);
    chk(e5 == 0, "R5 clock first on fall", e5, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule